// File: doc/BRIEF.md
# Section Activity Tracker and Access Classifier

This block sits beside the tag cache of a large set-associative memory-side cache. It keeps one small state machine per cache set that records whether the set's batch of tags is absent, being fetched, or held in the tag cache. A section is a contiguous run of blocks that all map to one set. Several sections are congruent modulo the set count and so share one set. Because of that, they also share one activity state.

Each lookup comes with its address and the tag-cache hit result. In the same cycle the block labels the access. It is leading if it finds its set inactive and misses the tag cache, which starts a tag-batch fetch. Otherwise it is following. The label therefore depends on the fill and eviction history of the set, and the address alone does not determine it. The placement and replacement logic consumes this label. Fill-completion and eviction events from the tag cache move the states on.

Top module: `sec_classifier`

## Requirements
- R1: The set of an address is `(addr >> (BLK_OFF_W + SEC_BLK_W)) mod 2**SET_W`. With the defaults (6, 2, 4), that is address bits [11:8]. `cls_set` reports it for every lookup.
- R2: After reset every set is inactive. The first tag-missing lookup to any set is labelled leading.
- R3: A lookup with `lkp_tc_hit`=0 to an inactive set is labelled leading (`cls_leading`=1), and the set becomes fetch-pending.
- R4: A lookup to a fetch-pending set is labelled following, whatever `lkp_tc_hit` shows, and does not start another fetch.
- R5: `fill_valid` with `fill_set` marks that set held. Lookups to a held set are labelled following, whatever `lkp_tc_hit` shows.
- R6: `evict_valid` with `evict_set` returns that set to inactive. The next tag-missing lookup to it is leading again, even if it targets a different block or another section of that set.
- R7: A lookup with `lkp_tc_hit`=1 to an inactive set is labelled following, and the set becomes held.
- R8: `cls_valid` equals `lkp_valid` in the same cycle, and `cls_leading` is 0 whenever `cls_valid` is 0.
- R9: A lookup is labelled from the set's state before the current clock edge. When events coincide for one set, the next state follows this priority: eviction, then fill, then lookup.
- R10: Events for one set leave every other set's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_valid | input | 1 | Lookup present this cycle |
| lkp_addr | input | ADDR_W | Lookup address |
| lkp_tc_hit | input | 1 | Tag-cache result for the lookup |
| fill_valid | input | 1 | Tag-batch fetch completed |
| fill_set | input | SET_W | Set whose tags arrived |
| evict_valid | input | 1 | Tag-cache entry evicted |
| evict_set | input | SET_W | Set whose tags left the tag cache |
| cls_valid | output | 1 | Classification qualifier |
| cls_leading | output | 1 | 1 = leading access, 0 = following |
| cls_set | output | SET_W | Set of the classified lookup |

## Verification
Directed sequences walk one set through one full episode: a leading miss, a repeat lookup while the fetch is pending, the fill, a held lookup that misses, the eviction, and a fresh leading access from a different section of the same set. Two further directed cases cover coincident events on one set. These show whether labels come from the state before the clock edge and whether eviction outranks the other events. Random traffic spreads addresses over all sets and mixes in fills and evictions for random sets. This separates a design that tracks per-set history from one that keys on the address alone or leaks an event into a neighbouring set.

// File: rtl/sec_cls_pkg.sv
package sec_cls_pkg;
  typedef enum logic [1:0] {
    SEC_IDLE = 2'd0,
    SEC_PEND = 2'd1,
    SEC_HELD = 2'd2
  } sec_state_e;
endpackage

// File: rtl/sec_addr_map.sv
module sec_addr_map #(
  parameter int ADDR_W    = 32,
  parameter int BLK_OFF_W = 6,
  parameter int SEC_BLK_W = 2,
  parameter int SET_W     = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SET_W-1:0]  set_idx
);
  localparam int SHIFT = BLK_OFF_W + SEC_BLK_W;

  // section number modulo set count: low bits of the shifted address
  function automatic logic [SET_W-1:0] section_to_set(input logic [ADDR_W-1:0] a);
    return SET_W'(a >> SHIFT);
  endfunction

  assign set_idx = section_to_set(addr);
endmodule

// File: rtl/sec_state_bank.sv
module sec_state_bank
  import sec_cls_pkg::*;
#(
  parameter int SET_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lkp_fire,
  input  logic [SET_W-1:0] lkp_set,
  input  logic             lkp_tc_hit,
  input  logic             fill_valid,
  input  logic [SET_W-1:0] fill_set,
  input  logic             evict_valid,
  input  logic [SET_W-1:0] evict_set,
  output sec_state_e       cur_state,
  output logic [(1<<SET_W)-1:0] active_vec
);
  localparam int NUM_SETS = 1 << SET_W;

  sec_state_e st_q [NUM_SETS];

  function automatic sec_state_e next_state(
    input sec_state_e cur, input logic ev, input logic fl,
    input logic lk, input logic hit);
    if (ev)                           return SEC_IDLE;
    if (fl)                           return SEC_HELD;
    if (lk && cur == SEC_IDLE)        return hit ? SEC_HELD : SEC_PEND;
    return cur;
  endfunction

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic ev_here, fl_here, lk_here;
    assign ev_here = evict_valid && (evict_set == SET_W'(s));
    assign fl_here = fill_valid  && (fill_set  == SET_W'(s));
    assign lk_here = lkp_fire    && (lkp_set   == SET_W'(s));

    always_ff @(posedge clk) begin
      if (!rst_n) st_q[s] <= SEC_IDLE;
      else        st_q[s] <= next_state(st_q[s], ev_here, fl_here, lk_here, lkp_tc_hit);
    end

    assign active_vec[s] = (st_q[s] != SEC_IDLE);
  end

  assign cur_state = st_q[lkp_set];
endmodule

// File: rtl/sec_label.sv
module sec_label
  import sec_cls_pkg::*;
(
  input  logic       lkp_valid,
  input  logic       lkp_tc_hit,
  input  sec_state_e set_state,
  output logic       lead_evt
);
  function automatic logic is_leading(input sec_state_e st, input logic hit);
    return (st == SEC_IDLE) && !hit;
  endfunction

  assign lead_evt = lkp_valid && is_leading(set_state, lkp_tc_hit);
endmodule

// File: rtl/sec_classifier.sv
module sec_classifier
  import sec_cls_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BLK_OFF_W = 6,
  parameter int SEC_BLK_W = 2,
  parameter int SET_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_valid,
  input  logic [ADDR_W-1:0] lkp_addr,
  input  logic              lkp_tc_hit,
  input  logic              fill_valid,
  input  logic [SET_W-1:0]  fill_set,
  input  logic              evict_valid,
  input  logic [SET_W-1:0]  evict_set,
  output logic              cls_valid,
  output logic              cls_leading,
  output logic [SET_W-1:0]  cls_set
);
  localparam int NUM_SETS = 1 << SET_W;

  logic [SET_W-1:0]    lkp_set;
  sec_state_e          lkp_state;
  logic                lead_evt;
  logic [NUM_SETS-1:0] active_vec;

  sec_addr_map #(
    .ADDR_W(ADDR_W), .BLK_OFF_W(BLK_OFF_W),
    .SEC_BLK_W(SEC_BLK_W), .SET_W(SET_W)
  ) u_map (
    .addr(lkp_addr), .set_idx(lkp_set)
  );

  sec_state_bank #(.SET_W(SET_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .lkp_fire(lkp_valid), .lkp_set(lkp_set), .lkp_tc_hit(lkp_tc_hit),
    .fill_valid(fill_valid), .fill_set(fill_set),
    .evict_valid(evict_valid), .evict_set(evict_set),
    .cur_state(lkp_state), .active_vec(active_vec)
  );

  sec_label u_label (
    .lkp_valid(lkp_valid), .lkp_tc_hit(lkp_tc_hit),
    .set_state(lkp_state), .lead_evt(lead_evt)
  );

  assign cls_valid   = lkp_valid;
  assign cls_leading = lead_evt;
  assign cls_set     = lkp_set;
endmodule

// File: rtl/sec_cls_chk.sv
module sec_cls_chk #(
  parameter int SET_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  lkp_valid,
  input logic                  lkp_tc_hit,
  input logic                  fill_valid,
  input logic [SET_W-1:0]      fill_set,
  input logic                  evict_valid,
  input logic [SET_W-1:0]      evict_set,
  input logic                  cls_valid,
  input logic                  cls_leading,
  input logic [SET_W-1:0]      cls_set,
  input logic [(1<<SET_W)-1:0] active_vec
);
  logic ev_on_cls, fl_on_cls;
  assign ev_on_cls = evict_valid && (evict_set == cls_set);
  assign fl_on_cls = fill_valid && (fill_set == cls_set);

  AST_LEAD_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_valid && cls_leading && !ev_on_cls) |=> active_vec[$past(cls_set)]); // R3

  AST_NO_SECOND_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_valid && cls_leading && !ev_on_cls) ##1 (cls_valid && cls_set == $past(cls_set))
    |-> !cls_leading); // R4

  AST_FILL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !(evict_valid && evict_set == fill_set)) |=> active_vec[$past(fill_set)]); // R5

  AST_EVICT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |=> !active_vec[$past(evict_set)]); // R6

  AST_HIT_NOT_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_valid && lkp_tc_hit) |-> !cls_leading); // R7

  AST_VALID_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_valid == lkp_valid) && (!cls_valid -> !cls_leading)); // R8

  AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!lkp_valid && !fill_valid && !evict_valid) |=> $stable(active_vec)); // R10

  AST_EVICT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_on_cls && fl_on_cls && cls_valid) |=> !active_vec[$past(cls_set)]); // R9
endmodule

bind sec_classifier sec_cls_chk #(.SET_W(SET_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_tc_hit(lkp_tc_hit),
  .fill_valid(fill_valid), .fill_set(fill_set),
  .evict_valid(evict_valid), .evict_set(evict_set),
  .cls_valid(cls_valid), .cls_leading(cls_leading), .cls_set(cls_set),
  .active_vec(active_vec)
);

// File: tb/tb_sec_classifier.sv
`timescale 1ns/1ps
module tb_sec_classifier;
  localparam int ADDR_W = 32, BLK_OFF_W = 6, SEC_BLK_W = 2, SET_W = 4;
  localparam int NSETS = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lkp_valid = 0, lkp_tc_hit = 0, fill_valid = 0, evict_valid = 0;
  logic [ADDR_W-1:0] lkp_addr = '0;
  logic [SET_W-1:0] fill_set = '0, evict_set = '0;
  logic cls_valid, cls_leading;
  logic [SET_W-1:0] cls_set;

  int errors = 0, checks = 0;
  int mstate [NSETS]; // 0 inactive, 1 pending, 2 held

  always #4 clk = ~clk;

  sec_classifier #(.ADDR_W(ADDR_W), .BLK_OFF_W(BLK_OFF_W),
                   .SEC_BLK_W(SEC_BLK_W), .SET_W(SET_W)) dut (.*);

  function automatic int addr_set(input logic [ADDR_W-1:0] a);
    return int'((a / 256) % NSETS);
  endfunction

  function automatic logic [ADDR_W-1:0] mk_addr(input int set, input int sec_hi, input int blk);
    return ADDR_W'(sec_hi) * 4096 + ADDR_W'(set) * 256 + ADDR_W'(blk) * 64;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  // drive at negedge, check 2ns later, update model for the coming edge
  task automatic step(input logic lv, input logic [ADDR_W-1:0] a, input logic hit,
                      input logic fv, input int fs, input logic ev, input int es,
                      input string req);
    int s;
    int exp_lead;
    @(negedge clk);
    lkp_valid = lv; lkp_addr = a; lkp_tc_hit = hit;
    fill_valid = fv; fill_set = SET_W'(fs); evict_valid = ev; evict_set = SET_W'(es);
    #2;
    s = addr_set(a);
    exp_lead = (lv && mstate[s] == 0 && !hit) ? 1 : 0;
    chk({req, " R8 valid"}, int'(cls_valid), int'(lv));
    chk({req, " leading"}, int'(cls_leading), exp_lead);
    if (lv) chk("R1 set", int'(cls_set), s);
    for (int k = 0; k < NSETS; k++) begin
      if (ev && es == k) mstate[k] = 0;
      else if (fv && fs == k) mstate[k] = 2;
      else if (lv && s == k && mstate[k] == 0) mstate[k] = hit ? 2 : 1;
    end
  endtask

  task automatic idle();
    step(0, '0, 0, 0, 0, 0, 0, "idle");
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int k = 0; k < NSETS; k++) mstate[k] = 0;
    repeat (3) @(negedge clk);
    chk("R8 reset valid", int'(cls_valid), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: every set inactive after reset
    step(1, mk_addr(5, 0, 1), 0, 0, 0, 0, 0, "R2 first lead");
    // R4: pending set, miss again: following
    step(1, mk_addr(5, 0, 2), 0, 0, 0, 0, 0, "R4 pending miss");
    step(1, mk_addr(5, 3, 0), 1, 0, 0, 0, 0, "R4 pending hit");
    // R5: fill then held miss (large-cache miss irrelevant)
    step(0, '0, 0, 1, 5, 0, 0, "R5 fill");
    step(1, mk_addr(5, 0, 3), 0, 0, 0, 0, 0, "R5 held miss");
    // R6: evict, another section of set 5 leads
    step(0, '0, 0, 0, 0, 1, 5, "R6 evict");
    step(1, mk_addr(5, 7, 2), 0, 0, 0, 0, 0, "R6 re-lead");
    // R7: hit on inactive set 9 -> following, then held
    step(1, mk_addr(9, 1, 0), 1, 0, 0, 0, 0, "R7 idle hit");
    step(1, mk_addr(9, 1, 1), 0, 0, 0, 0, 0, "R7 after hit");
    // R10: evicting 9 leaves 5 pending
    step(0, '0, 0, 0, 0, 1, 9, "R10 evict other");
    step(1, mk_addr(5, 2, 0), 0, 0, 0, 0, 0, "R10 neighbour kept");
    // R9: lookup + evict same cycle on inactive set 3: lead now, inactive next
    step(1, mk_addr(3, 0, 0), 0, 0, 0, 1, 3, "R9 lead with evict");
    step(1, mk_addr(3, 0, 1), 0, 0, 0, 0, 0, "R9 evict wins");
    // R9: fill + evict same cycle: evict wins
    step(0, '0, 0, 1, 12, 1, 12, "R9 fill evict");
    step(1, mk_addr(12, 0, 0), 0, 0, 0, 0, 0, "R9 fill evict result");
    idle();

    // random traffic
    void'($urandom(32'h5eed_c1a5));
    for (int i = 0; i < 4000; i++) begin
      logic lv, hit, fv, ev;
      lv  = ($urandom % 4) != 0;
      hit = ($urandom % 3) == 0;
      fv  = ($urandom % 5) == 0;
      ev  = ($urandom % 6) == 0;
      step(lv, $urandom, hit, fv, int'($urandom % NSETS), ev, int'($urandom % NSETS), "R3 random");
    end
    idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule